// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is the target side of a two-wire serial bus (I2C-style signalling, open-drain data) that exposes a bank of byte-wide configuration registers to a host. A write transaction carries the target address, then a command byte, then data. The command byte sets the starting register offset. Its top bit chooses between a single-register access and a run of registers at ascending offsets. Every data byte the target accepts goes into its register at once and appears on the parallel configuration output. A read is made as a write of the address and command byte, followed by a repeated START and the address with the read bit set.

A block read returns as many bytes as a count field in a register of the bank specifies. A control bit starts a commit of the whole bank into a non-volatile model, which is a timed copy. While the commit runs, a status bit and an output flag are high and reads keep working. Writes that arrive during the commit are acknowledged but discarded, and each one is counted.

SDA and SCL are sampled by the system clock through a synchronizer. The data pin is driven low only through `sda_oe_o`.

Top module: `cfg_serial_target`

## Requirements
- R1: The target answers only to the 7-bit address 0x6C (1101100), sent as {address, r/w} with 1 = read. It does not acknowledge any other address byte, and no later byte of that transaction is acknowledged or stored.
- R2: The target pulls SDA low during the ninth clock after a matching address byte, after a command byte, and after each data byte it accepts.
- R3: Command bit 7 = 1 selects single-register mode and 0 selects block mode. Bits 6:0 give the start offset, of which the low log2(NREG) bits are used.
- R4: An accepted data byte shows on `cfg_o` at its offset by the end of that byte's acknowledge clock.
- R5: Block writes fill ascending offsets and wrap from NREG-1 to 0. A STOP after any complete byte keeps every byte already written.
- R6: In a single-register write, the second and later data bytes are not acknowledged and are not stored.
- R7: Read data leaves most-significant bit first. A single-register read returns the register at the offset, and any further byte in that read returns 0xFF.
- R8: A block read returns N bytes from ascending, wrapping offsets, where N is bits 6:0 of register 2. Bytes past N return 0xFF, and N = 0 gives 0xFF at once.
- R9: Writing 1 to bit 0 of register 6 starts a commit, and that bit always reads 0. `commit_busy_o` and bit 6 of register 1 stay 1 for exactly COMMIT_CYCLES clocks. At the end of the commit, `nvm_o` equals the register bank.
- R10: Single and block reads return correct data while a commit runs.
- R11: A write during a commit is acknowledged but changes no register, and `err_cnt_o` rises by one for each such byte (saturating by default).
- R12: Bit 6 of register 1 is read-only. A written value there is dropped, and a read reports the commit flag.
- R13: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| commit_busy_o | output | 1 | Commit in progress |
| err_cnt_o | output | ERR_W | Count of writes dropped during a commit |
| cfg_o | output | NREG*8 | Register bank, register k in bits 8k+7:8k |
| nvm_o | output | NREG*8 | Non-volatile copy, same layout |

## Verification
The bench builds the target with NREG = 16, a 2-stage synchronizer, a 4-bit saturating error counter and COMMIT_CYCLES = 6000. With 16 registers, one block write covers the whole bank and the offset wrap, and a single-read pass checks every register. Command offsets above 15 then test that the unused upper offset bits are dropped. The commit window is long enough to fit status reads, block reads and rejected writes inside it, and the bench sweeps all 128 possible target addresses.

// File: rtl/cfg_st_pkg.sv
package cfg_st_pkg;

   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

   typedef enum logic [2:0] {
      LS_IDLE,
      LS_ADDR,
      LS_CMD,
      LS_WDATA,
      LS_RDATA,
      LS_HOLD
   } link_state_t;

endpackage

// File: rtl/cfg_st_busfront.sv
module cfg_st_busfront #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   logic [SYNC_STAGES-1:0] scl_p;
   logic [SYNC_STAGES-1:0] sda_p;
   logic                   scl_d;
   logic                   sda_d;
   logic                   scl_s;
   logic                   sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= '1;
         sda_p <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_p <= {scl_p[SYNC_STAGES-2:0], scl_i};
         sda_p <= {sda_p[SYNC_STAGES-2:0], sda_i};
         scl_d <= scl_p[SYNC_STAGES-1];
         sda_d <= sda_p[SYNC_STAGES-1];
      end
   end

   assign scl_s      = scl_p[SYNC_STAGES-1];
   assign sda_s      = sda_p[SYNC_STAGES-1];
   assign sda_s_o    = sda_s;
   assign scl_rise_o = scl_s & ~scl_d;
   assign scl_fall_o = ~scl_s & scl_d;
   assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfg_st_link.sv
module cfg_st_link
   import cfg_st_pkg::*;
#(
   parameter int         AW       = 7,
   parameter logic [6:0] DEV_ADDR = 7'h6C
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sda_s_i,
   input  logic          scl_rise_i,
   input  logic          scl_fall_i,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic [6:0]    blk_len_i,
   input  logic [7:0]    rd_data_i,
   output logic [AW-1:0] rd_addr_o,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [7:0]    wr_data_o,
   output logic          sda_oe_o
);

   link_state_t   st;
   logic [3:0]    cnt;
   logic [7:0]    sh;
   logic [6:0]    tx;
   logic [6:0]    left;
   logic [AW-1:0] ptr;
   logic          rnw;
   logic          single;
   logic          wdone;
   logic          hack;
   logic          oe;
   logic [6:0]    avail;
   logic          load_now;

   assign avail = (st == LS_RDATA) ? left : (single ? 7'd1 : blk_len_i);

   assign load_now = scl_fall_i && (cnt == 4'd9) &&
                     (((st == LS_ADDR) && rnw && oe) || ((st == LS_RDATA) && hack));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= LS_IDLE;
         cnt       <= '0;
         sh        <= '0;
         tx        <= '1;
         left      <= '0;
         ptr       <= '0;
         rnw       <= 1'b0;
         single    <= 1'b0;
         wdone     <= 1'b0;
         hack      <= 1'b0;
         oe        <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_i) begin
            st  <= LS_ADDR;
            cnt <= '0;
            oe  <= 1'b0;
         end else if (stop_i) begin
            st  <= LS_IDLE;
            cnt <= '0;
            oe  <= 1'b0;
         end else begin
            if ((st == LS_ADDR) || (st == LS_CMD) || (st == LS_WDATA)) begin
               if (scl_rise_i && (cnt < 4'd8)) begin
                  sh  <= {sh[6:0], sda_s_i};
                  cnt <= cnt + 4'd1;
               end else if (scl_fall_i && (cnt == 4'd8)) begin
                  cnt <= 4'd9;
                  if (st == LS_ADDR) begin
                     if (sh[7:1] == DEV_ADDR) begin
                        oe  <= 1'b1;
                        rnw <= sh[0];
                     end else begin
                        st  <= LS_IDLE;
                        cnt <= '0;
                     end
                  end else if (st == LS_CMD) begin
                     oe     <= 1'b1;
                     ptr    <= sh[AW-1:0];
                     single <= sh[7];
                     wdone  <= 1'b0;
                  end else if (!single || !wdone) begin
                     oe        <= 1'b1;
                     wr_en_o   <= 1'b1;
                     wr_addr_o <= ptr;
                     wr_data_o <= sh;
                     wdone     <= 1'b1;
                     if (!single) ptr <= ptr + 1'b1;
                  end
               end else if (scl_fall_i && (cnt == 4'd9)) begin
                  oe  <= 1'b0;
                  cnt <= '0;
                  if (st == LS_ADDR) st <= LS_CMD;
                  else if (st == LS_CMD) st <= LS_WDATA;
                  else if (!oe) st <= LS_HOLD;
               end
            end else if (st == LS_RDATA) begin
               if (scl_rise_i && (cnt < 4'd8)) begin
                  cnt <= cnt + 4'd1;
               end else if (scl_rise_i && (cnt == 4'd8)) begin
                  hack <= ~sda_s_i;
                  cnt  <= 4'd9;
               end else if (scl_fall_i && (cnt >= 4'd1) && (cnt <= 4'd7)) begin
                  oe <= ~tx[6];
                  tx <= {tx[5:0], 1'b1};
               end else if (scl_fall_i && (cnt == 4'd8)) begin
                  oe <= 1'b0;
               end else if (scl_fall_i && (cnt == 4'd9) && !hack) begin
                  st  <= LS_HOLD;
                  oe  <= 1'b0;
                  cnt <= '0;
               end
            end
            if (load_now) begin
               st  <= LS_RDATA;
               cnt <= '0;
               if (avail != 7'd0) begin
                  oe   <= ~rd_data_i[7];
                  tx   <= rd_data_i[6:0];
                  left <= avail - 7'd1;
                  if (!single) ptr <= ptr + 1'b1;
               end else begin
                  oe   <= 1'b0;
                  tx   <= IDLE_BYTE[6:0];
                  left <= '0;
               end
            end
         end
      end
   end

   assign rd_addr_o = ptr;
   assign sda_oe_o  = oe;

endmodule

// File: rtl/cfg_st_commit.sv
module cfg_st_commit #(
   parameter int COMMIT_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   localparam int CW = (COMMIT_CYCLES < 2) ? 1 : $clog2(COMMIT_CYCLES);

   logic [CW-1:0] remain;
   logic          busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (busy) begin
         if (remain == '0) busy <= 1'b0;
         else remain <= remain - 1'b1;
      end else if (start_i) begin
         busy   <= 1'b1;
         remain <= CW'(COMMIT_CYCLES - 1);
      end
   end

   assign busy_o = busy;
   assign done_o = busy && (remain == '0);

endmodule

// File: rtl/cfg_st_regbank.sv
module cfg_st_regbank #(
   parameter int NREG          = 128,
   parameter int AW            = 7,
   parameter int COMMIT_CYCLES = 1000,
   parameter int ERR_W         = 8,
   parameter bit ERR_WRAP      = 1'b0,
   parameter int STAT_REG      = 1,
   parameter int BUSY_BIT      = 6,
   parameter int CTRL_REG      = 6,
   parameter int TRIG_BIT      = 0,
   parameter int CNT_REG       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [AW-1:0]     wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic [6:0]        blk_len_o,
   output logic              busy_o,
   output logic [ERR_W-1:0]  err_cnt_o,
   output logic [NREG*8-1:0] cfg_o,
   output logic [NREG*8-1:0] nvm_o
);

   localparam logic [AW-1:0] STAT_A = AW'(STAT_REG);
   localparam logic [AW-1:0] CTRL_A = AW'(CTRL_REG);

   logic [7:0]       regs [NREG];
   logic [7:0]       wval;
   logic             busy;
   logic             done;
   logic             kick;
   logic             drop;
   logic [NREG*8-1:0] nvm;

   assign drop = wr_en_i && busy;
   assign kick = wr_en_i && !busy && (wr_addr_i == CTRL_A) && wr_data_i[TRIG_BIT];

   cfg_st_commit #(.COMMIT_CYCLES(COMMIT_CYCLES)) commit_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (kick),
      .busy_o  (busy),
      .done_o  (done)
   );

   always_comb begin
      wval = wr_data_i;
      if (wr_addr_i == STAT_A) wval[BUSY_BIT] = 1'b0;
      if (wr_addr_i == CTRL_A) wval[TRIG_BIT] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NREG; k++) regs[k] <= '0;
      end else if (wr_en_i && !busy) begin
         regs[wr_addr_i] <= wval;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nvm <= '0;
      else if (done) nvm <= cfg_o;
   end

   generate
      if (ERR_WRAP) begin : g_err_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_cnt_o <= '0;
            else if (drop) err_cnt_o <= err_cnt_o + 1'b1;
         end
      end else begin : g_err_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_cnt_o <= '0;
            else if (drop && (err_cnt_o != '1)) err_cnt_o <= err_cnt_o + 1'b1;
         end
      end
   endgenerate

   for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign cfg_o[g*8 +: 8] = regs[g];
   end

   always_comb begin
      rd_data_o = regs[rd_addr_i];
      if (rd_addr_i == STAT_A) rd_data_o[BUSY_BIT] = busy;
   end

   assign blk_len_o = regs[CNT_REG][6:0];
   assign busy_o    = busy;
   assign nvm_o     = nvm;

endmodule

// File: rtl/cfg_serial_target.sv
module cfg_serial_target #(
   parameter int         NREG          = 128,
   parameter logic [6:0] DEV_ADDR      = 7'h6C,
   parameter int         SYNC_STAGES   = 2,
   parameter int         COMMIT_CYCLES = 100000,
   parameter int         ERR_W         = 8,
   parameter bit         ERR_WRAP      = 1'b0,
   parameter int         STAT_REG      = 1,
   parameter int         BUSY_BIT      = 6,
   parameter int         CTRL_REG      = 6,
   parameter int         TRIG_BIT      = 0,
   parameter int         CNT_REG       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic              commit_busy_o,
   output logic [ERR_W-1:0]  err_cnt_o,
   output logic [NREG*8-1:0] cfg_o,
   output logic [NREG*8-1:0] nvm_o
);

   localparam int AW = $clog2(NREG);

   if ((NREG < 8) || (NREG > 128) || ((NREG & (NREG - 1)) != 0)) begin : g_bad_nreg
      $error("NREG must be a power of two between 8 and 128");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ((COMMIT_CYCLES < 1) || (ERR_W < 1)) begin : g_bad_cnt
      $error("COMMIT_CYCLES and ERR_W must be positive");
   end
   if ((STAT_REG >= NREG) || (CTRL_REG >= NREG) || (CNT_REG >= NREG) ||
       (STAT_REG == CTRL_REG) || (STAT_REG == CNT_REG) || (CTRL_REG == CNT_REG)) begin : g_bad_map
      $error("special register indices must be distinct and inside the bank");
   end
   if ((BUSY_BIT > 7) || (TRIG_BIT > 7)) begin : g_bad_bit
      $error("bit positions must lie within a byte");
   end

   logic          sda_s;
   logic          scl_rise;
   logic          scl_fall;
   logic          start_ev;
   logic          stop_ev;
   logic [6:0]    blk_len;
   logic [7:0]    rd_data;
   logic [AW-1:0] rd_addr;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;

   cfg_st_busfront #(.SYNC_STAGES(SYNC_STAGES)) front_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_s_o    (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_ev),
      .stop_o     (stop_ev)
   );

   cfg_st_link #(.AW(AW), .DEV_ADDR(DEV_ADDR)) link_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_s_i    (sda_s),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .start_i    (start_ev),
      .stop_i     (stop_ev),
      .blk_len_i  (blk_len),
      .rd_data_i  (rd_data),
      .rd_addr_o  (rd_addr),
      .wr_en_o    (wr_en),
      .wr_addr_o  (wr_addr),
      .wr_data_o  (wr_data),
      .sda_oe_o   (sda_oe_o)
   );

   cfg_st_regbank #(
      .NREG          (NREG),
      .AW            (AW),
      .COMMIT_CYCLES (COMMIT_CYCLES),
      .ERR_W         (ERR_W),
      .ERR_WRAP      (ERR_WRAP),
      .STAT_REG      (STAT_REG),
      .BUSY_BIT      (BUSY_BIT),
      .CTRL_REG      (CTRL_REG),
      .TRIG_BIT      (TRIG_BIT),
      .CNT_REG       (CNT_REG)
   ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .blk_len_o (blk_len),
      .busy_o    (commit_busy_o),
      .err_cnt_o (err_cnt_o),
      .cfg_o     (cfg_o),
      .nvm_o     (nvm_o)
   );

endmodule

// File: rtl/cfg_serial_target_chk.sv
module cfg_serial_target_chk #(
   parameter int NREG          = 128,
   parameter int COMMIT_CYCLES = 100000,
   parameter int ERR_W         = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe_o,
   input logic              commit_busy_o,
   input logic [ERR_W-1:0]  err_cnt_o,
   input logic [NREG*8-1:0] cfg_o,
   input logic [NREG*8-1:0] nvm_o
);

   int busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= 0;
      else if (commit_busy_o) busy_run <= busy_run + 1;
      else busy_run <= 0;
   end

   // R13
   sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

   // R9
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(commit_busy_o) |-> (busy_run == COMMIT_CYCLES));

   // R9
   nvm_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nvm_o != $past(nvm_o)) |-> $fell(commit_busy_o));

   // R11
   err_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt_o != $past(err_cnt_o)) |-> $past(commit_busy_o));

   // R11
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_o != $past(cfg_o)) |-> !$past(commit_busy_o));

endmodule

bind cfg_serial_target cfg_serial_target_chk #(
   .NREG          (NREG),
   .COMMIT_CYCLES (COMMIT_CYCLES),
   .ERR_W         (ERR_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_i         (scl_i),
   .sda_oe_o      (sda_oe_o),
   .commit_busy_o (commit_busy_o),
   .err_cnt_o     (err_cnt_o),
   .cfg_o         (cfg_o),
   .nvm_o         (nvm_o)
);

// File: tb/cfg_serial_target_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_target_tb_top;

   localparam int N      = 16;
   localparam int COMMIT = 6000;
   localparam int Q      = 6;
   localparam logic [7:0] AW_BYTE = 8'hD8;
   localparam logic [7:0] AR_BYTE = 8'hD9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic hsda = 1'b1;
   logic sda_oe;
   logic busy;
   logic [3:0] errc;
   logic [N*8-1:0] cfg;
   logic [N*8-1:0] nvm;
   wire  sda_line = hsda & ~sda_oe;

   always #4 clk = ~clk;

   cfg_serial_target #(
      .NREG(N), .SYNC_STAGES(2), .COMMIT_CYCLES(COMMIT), .ERR_W(4), .ERR_WRAP(1'b0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .commit_busy_o(busy), .err_cnt_o(errc), .cfg_o(cfg), .nvm_o(nvm)
   );

   int nchk = 0;
   int nerr = 0;
   int busy_len = 0;
   bit finished = 0;
   logic [7:0] m [N];
   logic [7:0] snap [N];
   logic [7:0] rbuf [24];
   bit ackv [24];

   always @(posedge clk) if (busy) busy_len <= busy_len + 1;

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'(i * 29 + 3) & 8'hFE;
   endfunction

   function automatic logic [7:0] cbyte(input int a);
      return cfg[a*8 +: 8];
   endfunction

   function automatic void mstore(input int a, input logic [7:0] d);
      logic [7:0] v = d;
      if (a == 1) v[6] = 1'b0;
      if (a == 6) v[0] = 1'b0;
      m[a] = v;
   endfunction

   function automatic logic [7:0] rdv(input int a, input bit b);
      logic [7:0] v = m[a];
      if (a == 1) v[6] = b;
      return v;
   endfunction

   task automatic bstart();
      hsda = 1'b1; hw(Q); scl = 1'b1; hw(Q); hsda = 1'b0; hw(Q); scl = 1'b0; hw(Q);
   endtask

   task automatic bstop();
      hsda = 1'b0; hw(Q); scl = 1'b1; hw(Q); hsda = 1'b1; hw(Q);
   endtask

   task automatic sendb(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         hsda = b[i]; hw(Q); scl = 1'b1; hw(2*Q); scl = 1'b0; hw(Q);
      end
      hsda = 1'b1; hw(Q); scl = 1'b1; hw(Q); ack = ~sda_line; hw(Q); scl = 1'b0; hw(Q);
   endtask

   task automatic recvb(output logic [7:0] b, input bit hack);
      for (int i = 7; i >= 0; i--) begin
         hsda = 1'b1; hw(Q); scl = 1'b1; hw(Q); b[i] = sda_line; hw(Q); scl = 1'b0; hw(Q);
      end
      hsda = ~hack; hw(Q); scl = 1'b1; hw(2*Q); scl = 1'b0; hw(Q); hsda = 1'b1;
   endtask

   task automatic do_read(input logic [7:0] cmd, input int n);
      bit a;
      bstart(); sendb(AW_BYTE, a); chk("R2 addr", a, 1);
      sendb(cmd, a); chk("R2 cmd", a, 1);
      bstart(); sendb(AR_BYTE, a); chk("R2 raddr", a, 1);
      for (int i = 0; i < n; i++) recvb(rbuf[i], i != n - 1);
      bstop();
   endtask

   task automatic do_write(input logic [7:0] cmd, input int n, input logic [7:0] d0, input logic [7:0] d1);
      bstart(); sendb(AW_BYTE, ackv[0]); sendb(cmd, ackv[1]);
      for (int i = 0; i < n; i++) sendb((i == 0) ? d0 : d1, ackv[i+2]);
      bstop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      bit a;
      for (int i = 0; i < N; i++) m[i] = 8'h00;
      hw(5); rst_n = 1'b1; hw(5);

      // reset state
      chk("R9 reset busy", busy, 0);
      chk("R11 reset err", errc, 0);
      chk("R4 reset cfg", (cfg == '0), 1);
      chk("R13 reset oe", sda_oe, 0);

      // R1 full address sweep
      for (int ad = 0; ad < 128; ad++) begin
         bstart(); sendb({7'(ad), 1'b0}, a); bstop();
         chk("R1 addr", a, (ad == 'h6C));
      end
      // R1 rest of a foreign transaction ignored
      bstart(); sendb(8'hAA, a); chk("R1 foreign", a, 0);
      sendb(8'h83, a); chk("R1 foreign cmd", a, 0);
      sendb(8'h99, a); chk("R1 foreign data", a, 0);
      bstop();
      chk("R1 no store", cbyte(3), 0);

      // R5 R4 block write of whole bank, immediate effect
      bstart(); sendb(AW_BYTE, a); chk("R2 addr", a, 1);
      sendb(8'h00, a); chk("R2 cmd", a, 1);
      for (int i = 0; i < N; i++) begin
         sendb(pat(i), a);
         mstore(i, pat(i));
         chk("R2 data ack", a, 1);
         chk("R4 immediate", cbyte(i), m[i]);
      end
      bstop();
      for (int i = 0; i < N; i++) chk("R5 bank", cbyte(i), m[i]);

      // R7 R3 single read of every register
      for (int i = 0; i < N; i++) begin
         do_read(8'h80 | 8'(i), 2);
         chk("R7 single", rbuf[0], rdv(i, 1'b0));
         chk("R7 fill", rbuf[1], 8'hFF);
      end

      // R6 single write: second byte refused
      do_write(8'h85, 2, 8'hA5, 8'h3C);
      chk("R6 ack1", ackv[2], 1);
      chk("R6 ack2", ackv[3], 0);
      mstore(5, 8'hA5);
      chk("R6 value", cbyte(5), 8'hA5);

      // R3 upper offset bits dropped
      do_write(8'hB3, 1, 8'h77, 8'h00);
      mstore(3, 8'h77);
      chk("R3 offset", cbyte(3), 8'h77);

      // R5 wrap and early stop
      do_write(8'h0E, 3, 8'h5A, 8'hC4);
      mstore(14, 8'h5A); mstore(15, 8'hC4); mstore(0, 8'hC4);
      chk("R5 wrap14", cbyte(14), m[14]);
      chk("R5 wrap15", cbyte(15), m[15]);
      chk("R5 wrap0", cbyte(0), m[0]);
      chk("R5 untouched", cbyte(1), m[1]);

      // R8 block read count sweep
      begin
         int clist [7] = '{0, 1, 2, 3, 5, 7, 16};
         for (int k = 0; k < 7; k++) begin
            int c = clist[k];
            int o = (k * 5 + 9) % N;
            do_write(8'h82, 1, 8'(c), 8'h00);
            mstore(2, 8'(c));
            do_read(8'(o), c + 2);
            for (int i = 0; i < c + 2; i++)
               chk("R8 block", rbuf[i], (i < c) ? rdv((o + i) % N, 1'b0) : 8'hFF);
         end
      end

      // R12 read-only status bit
      do_write(8'h81, 1, 8'hFF, 8'h00);
      mstore(1, 8'hFF);
      chk("R12 stored", cbyte(1), 8'hBF);
      do_read(8'h81, 1);
      chk("R12 read", rbuf[0], 8'hBF);

      // R9 commit
      do_write(8'h82, 1, 8'h04, 8'h00);
      mstore(2, 8'h04);
      do_write(8'h86, 1, 8'h03, 8'h00);
      mstore(6, 8'h03);
      for (int i = 0; i < N; i++) snap[i] = m[i];
      chk("R9 busy high", busy, 1);
      chk("R9 trigger clears", cbyte(6), 8'h02);
      do_read(8'h81, 1);
      chk("R9 status bit", rbuf[0], rdv(1, 1'b1));
      // R10 block read during commit
      do_read(8'h03, 5);
      for (int i = 0; i < 5; i++)
         chk("R10 busy read", rbuf[i], (i < 4) ? rdv(3 + i, 1'b1) : 8'hFF);
      // R11 writes dropped
      do_write(8'h89, 1, 8'h11, 8'h00);
      chk("R11 ack", ackv[2], 1);
      chk("R11 unchanged", cbyte(9), m[9]);
      chk("R11 count1", errc, 1);
      do_write(8'h0A, 2, 8'h22, 8'h33);
      chk("R11 count3", errc, 3);
      chk("R11 unchanged10", cbyte(10), m[10]);
      chk("R10 still busy", busy, 1);
      while (busy) hw(1);
      hw(2);
      chk("R9 busy length", busy_len, COMMIT);
      for (int i = 0; i < N; i++) chk("R9 nvm copy", nvm[i*8 +: 8], snap[i]);
      do_read(8'h81, 1);
      chk("R9 status clear", rbuf[0], rdv(1, 1'b0));
      do_write(8'h89, 1, 8'h11, 8'h00);
      mstore(9, 8'h11);
      chk("R11 write after", cbyte(9), 8'h11);
      chk("R11 count held", errc, 3);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule